// File: doc/BRIEF.md
# IO page table address translator

This block sits between a device-side DMA requester and system memory and turns each bus address into a system physical address. Three software-visible registers steer the decision: an IO base word whose bit 0 enables the translated range, a match mask, and the physical base of a single-level page directory. A request whose masked address equals the base word (with bit 0 cleared) is translated. Every other request goes straight through unchanged.

A translated request costs one 64-bit directory read on a valid/ready memory port. The block then returns either the physical page frame with the original 4 KiB page offset appended, or a fault. Only one request is in flight at a time. A request is accepted only while the block is idle, and its result appears as a one-cycle response strobe.

Top module: `iopt_xlate`

## Requirements
- R1: After synchronous reset all five registers read as zero, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: Registers sit at byte offsets 0x300 (IO base), 0x308 (match mask), 0x310 (purge command), 0x318 (config) and 0x320 (directory base), decoded on offset bits [11:3]. A write with `reg_wide`=1 replaces all 64 bits. A write with `reg_wide`=0 puts `reg_wdata[31:0]` into bits [31:0] when offset bit 2 is 0, or into bits [63:32] when it is 1, and leaves the other half unchanged. `reg_rdata` returns the register selected by `reg_rd_off`, and any other offset reads 0.
- R3: When bit 0 of the IO base is 0, an accepted request is returned with `rsp_addr` equal to `req_addr` and `rsp_fault`=0. `rsp_valid` is high in the cycle after acceptance, and no memory read is issued.
- R4: When bit 0 is 1 but (`req_addr` & mask) differs from the base with bit 0 cleared, the request is passed through as in R3, including any address above 4 GiB.
- R5: When bit 0 is 1 and the masked address matches, exactly one memory read is issued at directory base + (`req_addr` >> 12) * 8. The returned word is little-endian: address byte 0 is in bits [7:0].
- R6: If bit 63 of the returned entry is 1 and `mem_rsp_err` is 0, then `rsp_addr` = (entry with bit 63 and bits [11:0] cleared) | `req_addr[11:0]` and `rsp_fault`=0.
- R7: If bit 63 of the returned entry is 0, the response has `rsp_fault`=1 and `rsp_addr`=0.
- R8: If `mem_rsp_err` is 1 with the data, the response faults as in R7, whatever the entry holds.
- R9: `req_ready` is 0 from the cycle after acceptance until the cycle after `rsp_valid`, so at most one translation is outstanding.
- R10: The purge command and config registers are stored and read back, but their contents do not change any translation.
- R11: `rsp_valid` is a single-cycle strobe. `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1: 64-bit write, 0: 32-bit write |
| reg_wr_off | input | 12 | Register write byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rd_off | input | 12 | Register read byte offset |
| reg_rdata | output | 64 | Register read data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr | input | 64 | Device-side bus address |
| rsp_valid | output | 1 | Result strobe |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_fault | output | 1 | Translation failed |
| mem_req_valid | output | 1 | Directory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Directory entry address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Directory entry |
| mem_rsp_err | input | 1 | Read error |

## Verification
A walker state that is stuck shows at once as `req_ready` staying low or `rsp_valid` never rising, which trips the per-transaction timing check. A stale latched page offset or a wrong frame slice shows on the very next response, because the bench predicts every `rsp_addr` and compares it. A wrong directory address shows at the memory handshake itself. A register half written into the wrong place shows on the next read-back, and again on the next match decision as a passthrough where a lookup was expected.

// File: rtl/iopt_pkg.sv
// Shared constants and types for the IO page table translator.
// Assumes a 64-bit data path and 8-byte-aligned register words.
package iopt_pkg;
    localparam int unsigned DATA_W      = 64;
    localparam int unsigned PAGE_SHIFT  = 12;
    localparam int unsigned ENTRY_LOG2  = 3;
    localparam int unsigned OFF_W       = 12;
    localparam int unsigned IDX_W       = OFF_W - ENTRY_LOG2;
    localparam int unsigned NUM_REGS    = 5;
    localparam int unsigned FIRST_IDX   = 'h60;   // byte offset 0x300
    // Slot order follows consecutive word offsets.
    localparam int unsigned SLOT_BASE   = 0;
    localparam int unsigned SLOT_MASK   = 1;
    localparam int unsigned SLOT_PURGE  = 2;
    localparam int unsigned SLOT_CFG    = 3;
    localparam int unsigned SLOT_DIR    = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } walk_st_e;

    typedef struct packed {
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] dir;
    } xlate_cfg_t;
endpackage

// File: rtl/iopt_regs.sv
// Register file for the translator: five 64-bit words with 32/64-bit writes.
// Assumes offset bits [1:0] carry no meaning; unmapped reads return zero.
module iopt_regs
    import iopt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wide,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rdata,
    output xlate_cfg_t        cfg_o
);
    localparam int unsigned HALF = DATA_W / 2;

    logic [DATA_W-1:0] word_q [NUM_REGS];
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic              unused_off_bits;

    assign wr_idx = wr_off[OFF_W-1:ENTRY_LOG2];
    assign rd_idx = rd_off[OFF_W-1:ENTRY_LOG2];
    assign unused_off_bits = ^{wr_off[1:0], rd_off[ENTRY_LOG2-1:0]};

    // Combine new data with the old word according to access width and half.
    function automatic logic [DATA_W-1:0] merge_word(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic              full,
        input logic              upper
    );
        if (full)       return new_w;
        else if (upper) return {new_w[HALF-1:0], old_w[HALF-1:0]};
        else            return {old_w[DATA_W-1:HALF], new_w[HALF-1:0]};
    endfunction

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(FIRST_IDX + i);
        // Hold one register word, cleared on reset, updated on a decoded write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[i] <= '0;
            else if (wr_en && wr_idx == MY_IDX)
                word_q[i] <= merge_word(word_q[i], wdata, wide, wr_off[2]);
        end
    end

    // Select the word addressed by the read offset, zero when unmapped.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == IDX_W'(FIRST_IDX + i))
                rdata = word_q[i];
    end

    assign cfg_o.base = word_q[SLOT_BASE];
    assign cfg_o.mask = word_q[SLOT_MASK];
    assign cfg_o.dir  = word_q[SLOT_DIR];

    a_r2_wide_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wide && wr_idx == IDX_W'(FIRST_IDX + SLOT_MASK))
        |=> (cfg_o.mask == $past(wdata)));

    a_r2_low_half_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wide && !wr_off[2] && wr_idx == IDX_W'(FIRST_IDX + SLOT_DIR))
        |=> (cfg_o.dir[DATA_W-1:HALF] == $past(cfg_o.dir[DATA_W-1:HALF])));
endmodule

// File: rtl/iopt_match.sv
// Range decision and directory-entry address for one request address.
// Purely combinational; assumes 4 KiB pages and 8-byte directory entries.
module iopt_match
    import iopt_pkg::*;
(
    input  logic [DATA_W-1:0] addr,
    input  xlate_cfg_t        cfg,
    output logic              hit,
    output logic [DATA_W-1:0] entry_addr
);
    logic [DATA_W-1:0] page_bytes;

    // Lookup only when the range is enabled and the masked address matches.
    assign hit = cfg.base[0] && ((addr & cfg.mask) == {cfg.base[DATA_W-1:1], 1'b0});

    // Page number scaled by the entry size, added to the directory base.
    assign page_bytes = DATA_W'({addr[DATA_W-1:PAGE_SHIFT], {ENTRY_LOG2{1'b0}}});
    assign entry_addr = cfg.dir + page_bytes;
endmodule

// File: rtl/iopt_walker.sv
// Single-outstanding translation sequencer: accept, fetch entry, respond.
// Assumes the memory returns exactly one response per accepted read.
module iopt_walker
    import iopt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              hit,
    input  logic [DATA_W-1:0] entry_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [DATA_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_addr,
    output logic              rsp_fault
);
    localparam int unsigned VALID_BIT = DATA_W - 1;

    walk_st_e                st_q;
    logic [DATA_W-1:0]       fetch_q;
    logic [PAGE_SHIFT-1:0]   off_q;
    logic [DATA_W-1:0]       res_addr_q;
    logic                    res_fault_q;
    logic                    unused_entry_low;

    assign unused_entry_low = ^mem_rsp_data[PAGE_SHIFT-1:0];

    // Step through accept, fetch, wait and respond, capturing the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            fetch_q     <= '0;
            off_q       <= '0;
            res_addr_q  <= '0;
            res_fault_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (hit) begin
                            fetch_q <= entry_addr;
                            off_q   <= req_addr[PAGE_SHIFT-1:0];
                            st_q    <= ST_FETCH;
                        end else begin
                            res_addr_q  <= req_addr;
                            res_fault_q <= 1'b0;
                            st_q        <= ST_DONE;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_req_ready) st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err || !mem_rsp_data[VALID_BIT]) begin
                            res_addr_q  <= '0;
                            res_fault_q <= 1'b1;
                        end else begin
                            res_addr_q  <= {1'b0, mem_rsp_data[VALID_BIT-1:PAGE_SHIFT], off_q};
                            res_fault_q <= 1'b0;
                        end
                        st_q <= ST_DONE;
                    end
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (st_q == ST_IDLE);
    assign mem_req_valid = (st_q == ST_FETCH);
    assign mem_req_addr  = fetch_q;
    assign rsp_valid     = (st_q == ST_DONE);
    assign rsp_addr      = res_addr_q;
    assign rsp_fault     = res_fault_q;

    a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r3_passthrough_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !hit) |=> (rsp_valid && !rsp_fault));

    a_r5_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && hit) |=> (mem_req_valid && mem_req_addr == $past(entry_addr)));

    a_r11_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r11_rsp_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r7_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_addr == '0));
endmodule

// File: rtl/iopt_xlate.sv
// Top of the IO page table translator: registers, range match, walker.
// Assumes a single requester and a memory port with in-order responses.
module iopt_xlate
    import iopt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_wide,
    input  logic [OFF_W-1:0]  reg_wr_off,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [OFF_W-1:0]  reg_rd_off,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_addr,
    output logic              rsp_fault,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [DATA_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err
);
    xlate_cfg_t        cfg_s;
    logic              hit_s;
    logic [DATA_W-1:0] entry_addr_s;

    iopt_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .wide   (reg_wide),
        .wr_off (reg_wr_off),
        .wdata  (reg_wdata),
        .rd_off (reg_rd_off),
        .rdata  (reg_rdata),
        .cfg_o  (cfg_s)
    );

    iopt_match u_match (
        .addr       (req_addr),
        .cfg        (cfg_s),
        .hit        (hit_s),
        .entry_addr (entry_addr_s)
    );

    iopt_walker u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_ready     (req_ready),
        .hit           (hit_s),
        .entry_addr    (entry_addr_s),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .rsp_valid     (rsp_valid),
        .rsp_addr      (rsp_addr),
        .rsp_fault     (rsp_fault)
    );
endmodule

// File: tb/iopt_xlate_tb_top.sv
`timescale 1ns/1ps
module iopt_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_wide = 1'b0;
    logic [11:0] reg_wr_off = '0;
    logic [63:0] reg_wdata = '0;
    logic [11:0] reg_rd_off = '0;
    logic [63:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic        rsp_valid;
    logic [63:0] rsp_addr;
    logic        rsp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Reference state
    logic [63:0] m_regs [5];
    logic [63:0] mem_q [logic [63:0]];
    logic [63:0] exp_addr_q [$];
    logic        exp_fault_q [$];
    logic [63:0] exp_mem_q [$];
    int  rdy_delay = 0;
    int  rsp_lat   = 0;
    bit  mem_err   = 0;

    always #10 clk = ~clk;

    iopt_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_wide(reg_wide), .reg_wr_off(reg_wr_off),
        .reg_wdata(reg_wdata), .reg_rd_off(reg_rd_off), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%016h expected 0x%016h", rq, what, act, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles >= 50000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Response monitor, compared every clock (R6 R7 R8 R3 R4)
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_addr_q.size() == 0) begin
                check(1'b0, "R3", "unexpected response", rsp_addr, 64'h0);
            end else begin
                logic [63:0] ea;
                logic        ef;
                ea = exp_addr_q.pop_front();
                ef = exp_fault_q.pop_front();
                check(rsp_addr == ea, "R6", "rsp_addr", rsp_addr, ea);
                check(rsp_fault == ef, "R7", "rsp_fault", 64'(rsp_fault), 64'(ef));
            end
        end
    end

    // Memory responder and directory-read monitor (R5 R11)
    bit          prev_valid = 0;
    logic [63:0] prev_addr = '0;
    logic [63:0] held_addr = '0;
    bit          pend = 0;
    int          lat_cnt = 0;
    int          rdy_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_req_ready = 0; mem_rsp_valid = 0; pend = 0; rdy_cnt = 0; prev_valid = 0;
        end else begin
            mem_rsp_valid = 0;
            if (mem_req_ready && prev_valid) begin
                if (exp_mem_q.size() == 0)
                    check(1'b0, "R3", "memory read on passthrough", prev_addr, 64'h0);
                else begin
                    logic [63:0] em;
                    em = exp_mem_q.pop_front();
                    check(prev_addr == em, "R5", "directory address", prev_addr, em);
                end
                held_addr = prev_addr;
                mem_req_ready = 0; pend = 1; lat_cnt = rsp_lat;
            end
            if (pend) begin
                if (lat_cnt == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data  = mem_q.exists(held_addr) ? mem_q[held_addr] : 64'h0;
                    mem_rsp_err   = mem_err;
                    pend = 0;
                end else lat_cnt--;
            end
            if (mem_req_valid && !mem_req_ready && !pend) begin
                if (prev_valid)
                    check(mem_req_addr == prev_addr, "R11", "request address held", mem_req_addr, prev_addr);
                if (rdy_cnt >= rdy_delay) begin mem_req_ready = 1; rdy_cnt = 0; end
                else rdy_cnt++;
            end
            prev_valid = mem_req_valid;
            prev_addr  = mem_req_addr;
        end
    end

    task automatic wr_reg(input logic [11:0] off, input logic [63:0] d, input bit wide);
        int s;
        @(negedge clk);
        reg_wr = 1; reg_wide = wide; reg_wr_off = off; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        s = (int'(off) - 'h300) / 8;
        if (s >= 0 && s < 5) begin
            if (wide) m_regs[s] = d;
            else if (off[2]) m_regs[s] = {d[31:0], m_regs[s][31:0]};
            else m_regs[s] = {m_regs[s][63:32], d[31:0]};
        end
    endtask

    task automatic rd_check(input logic [11:0] off, input logic [63:0] exp, input string rq);
        reg_rd_off = off;
        #1;
        check(reg_rdata == exp, rq, $sformatf("read 0x%03h", off), reg_rdata, exp);
    endtask

    task automatic xlate(input logic [63:0] a, input string rq);
        bit          look;
        logic [63:0] fa;
        logic [63:0] ea;
        bit          ef;
        logic [63:0] e;
        bit          busy_bad;
        int          n;
        logic [63:0] msk_base;
        msk_base = m_regs[0] & ~64'h1;
        look = m_regs[0][0] && ((a & m_regs[1]) == msk_base);
        fa = m_regs[4] + (a / 4096) * 8;
        if (!look) begin ea = a; ef = 0; end
        else begin
            e = mem_q.exists(fa) ? mem_q[fa] : 64'h0;
            if (mem_err || e < 64'h8000_0000_0000_0000) begin ea = 0; ef = 1; end
            else begin ea = ((e - 64'h8000_0000_0000_0000) / 4096) * 4096 + (a % 4096); ef = 0; end
            exp_mem_q.push_back(fa);
        end
        exp_addr_q.push_back(ea);
        exp_fault_q.push_back(ef);
        @(negedge clk);
        req_valid = 1; req_addr = a;
        check(req_ready == 1, "R9", "ready when idle", 64'(req_ready), 64'h1);
        @(negedge clk);
        req_valid = 0;
        if (!look) begin
            check(rsp_valid == 1, rq, "passthrough response next cycle", 64'(rsp_valid), 64'h1);
        end else begin
            busy_bad = 0; n = 0;
            while (!rsp_valid && n < 100) begin
                if (req_ready) busy_bad = 1;
                @(negedge clk); n++;
            end
            check(!busy_bad, "R9", "ready low while busy", 64'(busy_bad), 64'h0);
            check(rsp_valid == 1, rq, "lookup completes", 64'(rsp_valid), 64'h1);
        end
        @(negedge clk);
        check(rsp_valid == 0, "R11", "single-cycle strobe", 64'(rsp_valid), 64'h0);
        check(req_ready == 1, "R9", "ready after response", 64'(req_ready), 64'h1);
    endtask

    localparam logic [63:0] A1 = 64'h0000_0000_8001_2345;
    localparam logic [63:0] A2 = 64'h0000_0000_8FFF_FFFF;
    localparam logic [63:0] A3 = 64'h0000_0000_8000_0ABC;
    localparam logic [63:0] A4 = 64'h0000_0000_8123_4001;

    initial begin
        for (int i = 0; i < 5; i++) m_regs[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int i = 0; i < 5; i++) rd_check(12'(12'h300 + 8 * i), 64'h0, "R1");
        check(req_ready == 1, "R1", "req_ready", 64'(req_ready), 64'h1);
        check(rsp_valid == 0, "R1", "rsp_valid", 64'(rsp_valid), 64'h0);
        check(mem_req_valid == 0, "R1", "mem_req_valid", 64'(mem_req_valid), 64'h0);

        // R2 register access
        wr_reg(12'h308, 64'hFFFF_FFFF_F000_0000, 1);
        rd_check(12'h308, m_regs[1], "R2");
        wr_reg(12'h320, 64'hDEAD_BEEF_0000_4000, 0);
        rd_check(12'h320, 64'h0000_0000_0000_4000, "R2");
        wr_reg(12'h324, 64'h1111_1111_0000_0010, 0);
        rd_check(12'h320, 64'h0000_0010_0000_4000, "R2");
        rd_check(12'h328, 64'h0, "R2");
        rd_check(12'h2F8, 64'h0, "R2");

        // R3 range disabled
        wr_reg(12'h300, 64'h0000_0000_8000_0000, 1);
        mem_q[m_regs[4] + (A1 / 4096) * 8] = 64'h8000_00AB_CDEF_0FFF;
        xlate(A1, "R3");
        xlate(64'h0001_2345_6789_ABCD, "R3");

        // R4 enabled but no match
        wr_reg(12'h300, 64'h0000_0000_8000_0001, 1);
        xlate(64'h0000_0000_9000_0123, "R4");
        xlate(64'h0000_0001_8000_0000, "R4");

        // R5 R6 lookups with varied memory timing
        mem_q[m_regs[4] + (A2 / 4096) * 8] = 64'hFFFF_FFFF_FFFF_FFFF;
        for (int d = 0; d < 3; d++)
            for (int l = 0; l < 4; l++) begin
                rdy_delay = d; rsp_lat = l;
                xlate(A1, "R6");
            end
        xlate(A2, "R6");

        // R7 invalid entries
        mem_q[m_regs[4] + (A3 / 4096) * 8] = 64'h7000_1234_5678_9000;
        xlate(A3, "R7");
        xlate(A4, "R7");

        // R8 memory error
        mem_err = 1;
        xlate(A1, "R8");
        mem_err = 0;

        // R10 purge and config stored, no effect
        wr_reg(12'h310, 64'hFFFF_FFFF_FFFF_FFFF, 1);
        wr_reg(12'h318, 64'h0123_4567_89AB_CDEF, 1);
        rd_check(12'h310, 64'hFFFF_FFFF_FFFF_FFFF, "R10");
        rd_check(12'h318, 64'h0123_4567_89AB_CDEF, "R10");
        xlate(A1, "R10");
        xlate(64'h0000_0000_9000_0123, "R10");

        repeat (3) @(negedge clk);
        check(exp_addr_q.size() == 0, "R11", "responses outstanding", 64'(exp_addr_q.size()), 64'h0);
        check(exp_mem_q.size() == 0, "R5", "reads outstanding", 64'(exp_mem_q.size()), 64'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule